// File: doc/BRIEF.md
# Instruction Prefetch Queue with Deferred Bus Fault

This block fetches instruction words from the bus before the decoder needs them and holds them in a short in-order queue. Each stored word carries a fault tag that records whether its bus cycle ended in an error. An error is not reported when the word arrives. It is reported only if the decoder actually tries to consume that word. At that point the block raises a one-cycle bus-error exception request that carries the fetch address of the word. The faulted word is never presented as a valid instruction.

A flush input covers both branches and task switches. A flush empties the queue, drops any pending fault without reporting it, and restarts fetching at a new target address. A response to a fetch that was still in flight when the flush arrived is thrown away. After a faulted fetch the block issues no further requests until the fault is consumed or flushed. The bus side has at most one request outstanding. A request is a one-cycle pulse, and it is answered by a done pulse in a later cycle.

Top module: `pfq_core`

## Requirements
- R1: After reset the block requests address RESET_ADDR (default 0x100), presents no valid instruction and raises no exception request.
- R2: Held words plus the outstanding fetch never exceed DEPTH (default 3). With no consumption, exactly DEPTH requests are issued and fetching then stops.
- R3: Words are delivered in fetch order. Each word comes with its own fetch address and the data returned for it, and successive fetch addresses rise by ADDR_STEP (default 2).
- R4: A response with fetch_err_i high raises no exception request when it arrives.
- R5: When the decoder asserts insn_ready_i while the head word is faulted, berr_req_o is high for exactly one cycle, berr_addr_o equals that word's fetch address, insn_valid_o stays low, and the word is removed.
- R6: A flush before a faulted word is consumed cancels the fault, so no exception request follows. In a cycle with flush_i high, neither an instruction nor an exception request is delivered.
- R7: After a faulted response is accepted, no new request is issued until the fault is consumed or flushed. Fetching then resumes at the next sequential address.
- R8: The first request after a flush goes to flush_target_i. A response to a fetch outstanding at the time of the flush is discarded, including any error it carries.
- R9: No request is issued while a response is outstanding, including a response made stale by a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_o | output | 1 | One-cycle fetch request pulse |
| fetch_addr_o | output | ADDR_W | Address of the requested word |
| fetch_done_i | input | 1 | Response pulse for the outstanding fetch |
| fetch_err_i | input | 1 | Response ended with a bus error |
| fetch_data_i | input | DATA_W | Returned instruction word |
| insn_valid_o | output | 1 | Head word is valid and not faulted |
| insn_ready_i | input | 1 | Decoder takes or tries to take the head word |
| insn_data_o | output | DATA_W | Head instruction word |
| insn_addr_o | output | ADDR_W | Fetch address of the head word |
| berr_req_o | output | 1 | Bus-error exception request |
| berr_addr_o | output | ADDR_W | Fetch address of the faulted word |
| flush_i | input | 1 | Branch or task switch: flush and redirect |
| flush_target_i | input | ADDR_W | New fetch address after a flush |

## Verification
The hardest state to reach is a stale fetch. A request must be in flight when the flush arrives, and its response, which is itself an error, must land only after the redirect. The bench first fills the queue, then consumes one word so that a single new request issues. It lengthens the bus model's latency to four cycles and flushes while that request is pending. It then checks that no request goes out until the late response has arrived, that the erroring response leaves no fault behind, and that the first delivered word comes from the flush target. The deferred-fault path is reached by programming the bus model to fail one chosen address just past a flush target.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 16;

  typedef struct packed {
    logic              fault;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } pfq_entry_t;
endpackage

// File: rtl/pfq_fifo.sv
module pfq_fifo
  import pfq_pkg::*;
#(
  parameter int unsigned DEPTH = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       push_i,
  input  pfq_entry_t entry_i,
  input  logic       pop_i,
  output pfq_entry_t head_o,
  output logic       head_valid_o,
  output logic       full_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  pfq_entry_t          mem_q [DEPTH];
  logic [PW-1:0]       rd_q, wr_q;
  logic [CW-1:0]       cnt_q;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_i && !clear_i && wr_q == PW'(g)) mem_q[g] <= entry_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= ptr_next(wr_q);
      if (pop_i)  rd_q <= ptr_next(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign head_o       = mem_q[rd_q];
  assign head_valid_o = (cnt_q != '0);
  assign full_o       = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch
  import pfq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h100,
  parameter int unsigned       ADDR_STEP  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_target_i,
  input  logic              full_i,
  input  logic              fault_clr_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  input  logic              done_i,
  input  logic              err_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              push_o,
  output pfq_entry_t        entry_o
);
  logic [ADDR_W-1:0] pc_q, req_addr_q;
  logic              busy_q, stale_q, fault_q;
  logic              accept;

  assign req_o   = !busy_q && !full_i && !fault_q && !flush_i;
  assign addr_o  = pc_q;
  assign accept  = busy_q && done_i && !stale_q && !flush_i;
  assign push_o  = accept;
  assign entry_o = '{fault: err_i, addr: req_addr_q, data: data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q       <= RESET_ADDR;
      req_addr_q <= '0;
      busy_q     <= 1'b0;
      stale_q    <= 1'b0;
      fault_q    <= 1'b0;
    end else if (flush_i) begin
      pc_q    <= flush_target_i;
      fault_q <= 1'b0;
      // an in-flight response still has to drain; mark it for dropping
      busy_q  <= busy_q && !done_i;
      stale_q <= busy_q && !done_i;
    end else begin
      if (req_o) begin
        busy_q     <= 1'b1;
        req_addr_q <= pc_q;
        pc_q       <= pc_q + ADDR_W'(ADDR_STEP);
      end
      if (busy_q && done_i) begin
        busy_q  <= 1'b0;
        stale_q <= 1'b0;
      end
      if (accept && err_i)  fault_q <= 1'b1;
      else if (fault_clr_i) fault_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pfq_core.sv
module pfq_core
  import pfq_pkg::*;
#(
  parameter int unsigned       DEPTH      = 3,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h100,
  parameter int unsigned       ADDR_STEP  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic              fetch_done_i,
  input  logic              fetch_err_i,
  input  logic [DATA_W-1:0] fetch_data_i,
  output logic              insn_valid_o,
  input  logic              insn_ready_i,
  output logic [DATA_W-1:0] insn_data_o,
  output logic [ADDR_W-1:0] insn_addr_o,
  output logic              berr_req_o,
  output logic [ADDR_W-1:0] berr_addr_o,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_target_i
);
  pfq_entry_t head, wr_entry;
  logic       head_valid, full, push, pop;

  pfq_fetch #(
    .RESET_ADDR(RESET_ADDR),
    .ADDR_STEP (ADDR_STEP)
  ) i_fetch (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_i       (flush_i),
    .flush_target_i(flush_target_i),
    .full_i        (full),
    .fault_clr_i   (berr_req_o),
    .req_o         (fetch_req_o),
    .addr_o        (fetch_addr_o),
    .done_i        (fetch_done_i),
    .err_i         (fetch_err_i),
    .data_i        (fetch_data_i),
    .push_o        (push),
    .entry_o       (wr_entry)
  );

  pfq_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (flush_i),
    .push_i      (push),
    .entry_i     (wr_entry),
    .pop_i       (pop),
    .head_o      (head),
    .head_valid_o(head_valid),
    .full_o      (full)
  );

  // flush wins over delivery and over the deferred fault
  assign insn_valid_o = head_valid && !head.fault && !flush_i;
  assign berr_req_o   = head_valid && head.fault && insn_ready_i && !flush_i;
  assign pop          = (insn_valid_o && insn_ready_i) || berr_req_o;
  assign insn_data_o  = head.data;
  assign insn_addr_o  = head.addr;
  assign berr_addr_o  = head.addr;
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker
  import pfq_pkg::*;
#(
  parameter int unsigned DEPTH = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_req_o,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              fetch_done_i,
  input logic              fetch_err_i,
  input logic              insn_valid_o,
  input logic              insn_ready_i,
  input logic              berr_req_o,
  input logic              flush_i,
  input logic [ADDR_W-1:0] flush_target_i
);
  logic        out_q, stale_q, fault_q;
  logic [15:0] held_q;
  logic        wr, rd;

  assign wr = fetch_done_i && out_q && !stale_q && !flush_i;
  assign rd = (insn_valid_o && insn_ready_i) || berr_req_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= 1'b0;
      stale_q <= 1'b0;
      fault_q <= 1'b0;
      held_q  <= '0;
    end else begin
      if (fetch_req_o) out_q <= 1'b1;
      else if (fetch_done_i) out_q <= 1'b0;
      if (flush_i && out_q && !fetch_done_i) stale_q <= 1'b1;
      else if (fetch_done_i) stale_q <= 1'b0;
      if (flush_i || berr_req_o) fault_q <= 1'b0;
      else if (wr && fetch_err_i) fault_q <= 1'b1;
      if (flush_i) held_q <= '0;
      else held_q <= held_q + 16'(wr) - 16'(rd);
    end
  end

  a_r9_single_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> !out_q);
  a_r2_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q + 16'(out_q)) <= 16'(DEPTH));
  a_r5_berr_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_req_o |=> !berr_req_o);
  a_r5_berr_not_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_req_o |-> !insn_valid_o);
  a_r6_flush_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (!berr_req_o && !insn_valid_o));
  a_r7_fault_stops_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q |-> !fetch_req_o);
  a_r8_flush_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!fetch_req_o || fetch_addr_o == $past(flush_target_i)));
  a_r8_stale_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stale_q && fetch_done_i && !flush_i && held_q == '0) |=> (!insn_valid_o && !berr_req_o));
endmodule

bind pfq_core pfq_checker #(.DEPTH(DEPTH)) i_pfq_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_req_o   (fetch_req_o),
  .fetch_addr_o  (fetch_addr_o),
  .fetch_done_i  (fetch_done_i),
  .fetch_err_i   (fetch_err_i),
  .insn_valid_o  (insn_valid_o),
  .insn_ready_i  (insn_ready_i),
  .berr_req_o    (berr_req_o),
  .flush_i       (flush_i),
  .flush_target_i(flush_target_i)
);

// File: tb/test_pfq_core.sv
module test_pfq_core;
  logic        clk, rst_ni;
  logic        fetch_req_o, fetch_done_i, fetch_err_i;
  logic [31:0] fetch_addr_o;
  logic [15:0] fetch_data_i;
  logic        insn_valid_o, insn_ready_i, berr_req_o, flush_i;
  logic [15:0] insn_data_o;
  logic [31:0] insn_addr_o, berr_addr_o, flush_target_i;

  int n_chk = 0, n_err = 0;
  int nreq = 0, berr_seen = 0;
  int lat = 1, cnt = 0;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0, lat_addr = '0;

  pfq_core i_pfq_core (
    .clk_i(clk), .rst_ni(rst_ni),
    .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
    .fetch_done_i(fetch_done_i), .fetch_err_i(fetch_err_i), .fetch_data_i(fetch_data_i),
    .insn_valid_o(insn_valid_o), .insn_ready_i(insn_ready_i),
    .insn_data_o(insn_data_o), .insn_addr_o(insn_addr_o),
    .berr_req_o(berr_req_o), .berr_addr_o(berr_addr_o),
    .flush_i(flush_i), .flush_target_i(flush_target_i)
  );

  initial begin clk = 1'b0; forever #5 clk = ~clk; end

  function automatic logic [15:0] dfun(input logic [31:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus model: one response per request after lat cycles
  initial begin
    fetch_done_i = 1'b0; fetch_err_i = 1'b0; fetch_data_i = '0;
    forever begin
      @(negedge clk); #1;
      fetch_done_i = 1'b0; fetch_err_i = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          fetch_done_i = 1'b1;
          fetch_data_i = dfun(lat_addr);
          fetch_err_i  = err_en && (lat_addr == err_addr);
        end
      end else if (rst_ni && fetch_req_o) begin
        cnt = lat; lat_addr = fetch_addr_o; nreq++;
      end
    end
  end

  initial forever begin
    @(negedge clk); #3;
    if (berr_req_o) berr_seen++;
  end

  task automatic do_flush(input logic [31:0] tgt);
    @(negedge clk); flush_i = 1'b1; flush_target_i = tgt;
    @(negedge clk); flush_i = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); rst_ni = 1'b1; #2;
    chk("R1 req", fetch_req_o, 1);
    chk("R1 addr", fetch_addr_o, 32'h100);
    chk("R1 valid", insn_valid_o, 0);
    chk("R1 berr", berr_req_o, 0);
  endtask

  task automatic t_fill;
    repeat (20) @(negedge clk); #2;
    chk("R2 requests until full", nreq, 3);
    chk("R2 fetch stopped", fetch_req_o, 0);
    chk("R3 head addr", insn_addr_o, 32'h100);
  endtask

  task automatic t_drain;
    @(negedge clk); insn_ready_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      if (i > 0) @(negedge clk);
      #2;
      chk("R3 valid", insn_valid_o, 1);
      chk("R3 order addr", insn_addr_o, 32'h100 + 32'(2 * i));
      chk("R3 data", insn_data_o, dfun(32'h100 + 32'(2 * i)));
    end
    @(negedge clk); insn_ready_i = 1'b0;
    repeat (20) @(negedge clk); #2;
    chk("R2 refill count", nreq, 6);
    chk("R3 refill head", insn_addr_o, 32'h106);
  endtask

  task automatic t_fault_defer;
    int n0;
    err_en = 1'b1; err_addr = 32'h202;
    do_flush(32'h200);
    n0 = nreq;
    repeat (20) @(negedge clk); #2;
    chk("R4 no exception at fetch", berr_seen, 0);
    chk("R7 fetch halts after fault", nreq - n0, 2);
    chk("R8 target head", insn_addr_o, 32'h200);
    @(negedge clk); insn_ready_i = 1'b1; #2;
    chk("R5 good word first", insn_valid_o, 1);
    @(negedge clk); #2;
    chk("R5 faulted not valid", insn_valid_o, 0);
    chk("R5 berr raised", berr_req_o, 1);
    chk("R5 berr addr", berr_addr_o, 32'h202);
    @(negedge clk); #2;
    chk("R5 berr one cycle", berr_req_o, 0);
    insn_ready_i = 1'b0; err_en = 1'b0;
    repeat (10) @(negedge clk); #2;
    chk("R7 resumes sequentially", insn_addr_o, 32'h204);
    chk("R5 single pulse", berr_seen, 1);
  endtask

  task automatic t_fault_flush;
    err_en = 1'b1; err_addr = 32'h302;
    do_flush(32'h300);
    repeat (10) @(negedge clk);
    insn_ready_i = 1'b1; #2;
    chk("R3 head 300", insn_addr_o, 32'h300);
    @(negedge clk); flush_i = 1'b1; flush_target_i = 32'h400; #2;
    chk("R6 flush beats berr", berr_req_o, 0);
    chk("R6 flush blocks valid", insn_valid_o, 0);
    @(negedge clk); flush_i = 1'b0; insn_ready_i = 1'b0; err_en = 1'b0;
    repeat (10) @(negedge clk); #2;
    chk("R6 fault cancelled", berr_seen, 1);
    chk("R8 redirect head", insn_addr_o, 32'h400);
  endtask

  task automatic t_stale;
    lat = 4; err_en = 1'b1; err_addr = 32'h406;
    @(negedge clk); insn_ready_i = 1'b1;
    @(negedge clk); insn_ready_i = 1'b0;
    do_flush(32'h600);
    #2;
    chk("R9 no request while stale", fetch_req_o, 0);
    chk("R8 queue emptied", insn_valid_o, 0);
    repeat (30) @(negedge clk); #2;
    chk("R8 stale dropped head", insn_addr_o, 32'h600);
    chk("R8 stale data", insn_data_o, dfun(32'h600));
    chk("R8 stale error ignored", insn_valid_o, 1);
    chk("R8 no berr from stale", berr_seen, 1);
    lat = 1; err_en = 1'b0;
  endtask

  initial begin
    rst_ni = 1'b0; insn_ready_i = 1'b0; flush_i = 1'b0; flush_target_i = '0;
    repeat (2) @(negedge clk);
    t_reset();
    t_fill();
    t_drain();
    t_fault_defer();
    t_fault_flush();
    t_stale();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule